// File: doc/BRIEF.md
# PCI DMA Window Address Translator

This block maps inbound PCI bus-master addresses onto system memory addresses. Software programs a small bank of translation windows and one control register. Each window holds three values: a match base, a size mask and a translated base. An address that falls inside an enabled window is relocated in one of two ways. In the linear mode the translated base is merged with the low address bits. In the paged mode the block reads one 64-bit page-table entry from memory and builds the result from it.

Addresses below 4 GiB are compared against the windows in fixed priority order. Addresses at or above 4 GiB are handled separately. They can use a large pass-through range when the control register enables it. They can also use a paged range that is served by the last window once it is switched into wide-address mode. The block takes one translation request at a time over a valid/ready handshake. It answers with a one-cycle response pulse that carries a hit flag and the 35-bit system address. Page-table reads go out over a request/response memory port.

Top module: `pci_dma_xlat`

## Requirements
- R1: The register port selects a register through `reg_sel = {kind[1:0], win[1:0]}`, where kind 0 is the match base, 1 is the size mask, 2 is the translated base and 3 is the control register (any win). Reads are combinational. For windows 0–2, a write keeps these bits and zeroes the rest: bits 31:20, 1 and 0 of the match base; bits 31:20 of the size mask; bits 34:10 of the translated base. All registers reset to zero except as stated in R2.
- R2: Window 3's match base always reads bit 1 (paged mode) as 1, including its reset value of 0x2. A write keeps bits 39, 31:20 and 0. Bit 39 is the wide-address enable.
- R3: The control register stores only the bits of 0x1C_FF0F_C7FF and resets to 0. Bit 5 enables the ISA hole. Bit 6 enables the pass-through range.
- R4: An address below 4 GiB hits window w under three conditions: base bit 0 is set, (addr AND NOT (mask OR 0xFFFFF)) equals base bits 31:20, and, for window 3 only, base bit 39 is clear. The lowest-numbered hitting window wins. If no window hits, the result is a miss.
- R5: In a hitting window with base bit 1 clear, the result is (tbase AND NOT ext) OR (addr AND ext), where ext = mask OR 0xFFFFF.
- R6: In a hitting window with base bit 1 set, the block reads the entry at (tbase AND NOT (mask >> 10)) OR ((addr AND (mask OR 0xFE000)) >> 10). If entry bit 0 is set, the result is ((entry AND 0x3FFFFE) << 12) OR (addr AND 0x1FFF). Otherwise the result is a miss. The read address stays stable until it is accepted.
- R7: While control bit 5 is set, every address from 0x80000 to 0xFFFFF misses, whatever the windows hold.
- R8: While control bit 6 is set, an address in [2^40, 2^41) hits with result addr[34:0].
- R9: An address in [2^43, 2^44) is served only when window 3 has both bit 0 and bit 39 set. The entry is then read from (tbase AND 0x7_FFC0_0000) OR ((addr AND 0xFFFF_E000) >> 10) and is used as in R6. Otherwise the address misses.
- R10: `req_ready` is high only when no translation is in flight. A response that needs no memory read appears in the cycle after acceptance. A paged response appears in the cycle after `mem_rsp_valid`. A miss always reports address 0.
- R11: Any address at or above 4 GiB that is covered by neither R8 nor R9 misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 4 | Register select {kind, window} |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for `reg_sel` |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Translator idle, request accepted |
| req_addr | input | 44 | PCI address to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_addr | output | 35 | System address (0 on miss) |
| mem_req_valid | output | 1 | Page-table read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 35 | Page-table entry address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Page-table entry |

## Verification
Some properties are checked on every cycle against the control state and the port traffic:
- the hole and pass-through decisions;
- the rule that a miss never carries an address;
- the hold of a pending page-table read;
- the exclusion between a pending read and a new request;
- the forced paged bit of window 3 and the control-register mask.

Other behaviour is shown only by the bench scenarios, which compare against a behavioural model:
- the window match rule and the priority between overlapping windows;
- the exact linear and paged address arithmetic and invalid entries;
- the wide-address window enable and disable sequence;
- response timing under varied memory latency.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

    localparam int ADDR_W = 44;
    localparam int SYS_W  = 35;
    localparam int DATA_W = 64;

    localparam logic [63:0] BASE_KEEP      = 64'h0000_0000_FFF0_0003;
    localparam logic [63:0] BASE_KEEP_LAST = 64'h0000_0080_FFF0_0001;
    localparam logic [63:0] MASK_KEEP      = 64'h0000_0000_FFF0_0000;
    localparam logic [63:0] TBA_KEEP       = 64'h0000_0007_FFFF_FC00;
    localparam logic [63:0] CTL_KEEP       = 64'h0000_001C_FF0F_C7FF;

    localparam int EN_BIT   = 0;
    localparam int PG_BIT   = 1;
    localparam int WIDE_BIT = 39;
    localparam int HOLE_BIT = 5;
    localparam int PASS_BIT = 6;

    typedef enum logic [1:0] {
        RK_BASE = 2'd0,
        RK_MASK = 2'd1,
        RK_TBA  = 2'd2,
        RK_CTL  = 2'd3
    } rkind_e;

    typedef enum logic [1:0] {
        ACT_MISS   = 2'd0,
        ACT_DIRECT = 2'd1,
        ACT_FETCH  = 2'd2
    } act_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WAIT  = 2'd2
    } st_e;

    typedef struct packed {
        act_e              act;
        logic [SYS_W-1:0]  sys;
        logic [SYS_W-1:0]  pte;
    } plan_t;

    function automatic logic [SYS_W-1:0] linear_map(
        input logic [63:0] tba, input logic [63:0] mask, input logic [ADDR_W-1:0] a);
        logic [SYS_W-1:0] ext;
        ext = mask[SYS_W-1:0] | 35'h0_000F_FFFF;
        return (tba[SYS_W-1:0] & ~ext) | (a[SYS_W-1:0] & ext);
    endfunction

    function automatic logic [SYS_W-1:0] paged_entry_addr(
        input logic [63:0] tba, input logic [63:0] mask, input logic [ADDR_W-1:0] a);
        logic [SYS_W-1:0] hi;
        logic [31:0]      lo;
        hi = tba[SYS_W-1:0] & ~(mask[SYS_W-1:0] >> 10);
        lo = a[31:0] & (mask[31:0] | 32'h000F_E000);
        return hi | ({3'b000, lo} >> 10);
    endfunction

    function automatic logic [SYS_W-1:0] wide_entry_addr(
        input logic [63:0] tba, input logic [ADDR_W-1:0] a);
        logic [31:0] lo;
        lo = a[31:0] & 32'hFFFF_E000;
        return (tba[SYS_W-1:0] & 35'h7_FFC0_0000) | ({3'b000, lo} >> 10);
    endfunction

    function automatic logic [SYS_W-1:0] entry_to_sys(
        input logic [DATA_W-1:0] pte, input logic [12:0] off);
        return {1'b0, pte[21:1], off};
    endfunction

endpackage

// File: rtl/dmx_regs.sv
module dmx_regs
    import dmx_pkg::*;
#(
    parameter int NWIN  = 4,
    parameter int WIN_W = 2,
    parameter int SEL_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [SEL_W-1:0]  sel,
    input  logic [63:0]       wdata,
    output logic [63:0]       rdata,
    output logic [63:0]       base_o [NWIN],
    output logic [63:0]       mask_o [NWIN],
    output logic [63:0]       tba_o  [NWIN],
    output logic [63:0]       ctl_o
);

    rkind_e           kind;
    logic [WIN_W-1:0] idx;
    logic [63:0]      ctl_q;

    assign kind  = rkind_e'(sel[SEL_W-1 -: 2]);
    assign idx   = sel[WIN_W-1:0];
    assign ctl_o = ctl_q;

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        logic        sel_w;
        logic [63:0] base_q, mask_q, tba_q;

        assign sel_w = we && (int'(idx) == w);

        if (w == NWIN - 1) begin : g_last
            always_ff @(posedge clk) begin
                if (rst) begin
                    base_q <= 64'h2;
                end else if (sel_w && kind == RK_BASE) begin
                    base_q <= (wdata & BASE_KEEP_LAST) | 64'h2;
                end
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (rst) begin
                    base_q <= '0;
                end else if (sel_w && kind == RK_BASE) begin
                    base_q <= wdata & BASE_KEEP;
                end
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                mask_q <= '0;
                tba_q  <= '0;
            end else begin
                if (sel_w && kind == RK_MASK) mask_q <= wdata & MASK_KEEP;
                if (sel_w && kind == RK_TBA)  tba_q  <= wdata & TBA_KEEP;
            end
        end

        assign base_o[w] = base_q;
        assign mask_o[w] = mask_q;
        assign tba_o[w]  = tba_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else if (we && kind == RK_CTL) begin
            ctl_q <= wdata & CTL_KEEP;
        end
    end

    always_comb begin
        rdata = '0;
        if (kind == RK_CTL) begin
            rdata = ctl_q;
        end else if (int'(idx) < NWIN) begin
            case (kind)
                RK_BASE: rdata = base_o[idx];
                RK_MASK: rdata = mask_o[idx];
                RK_TBA:  rdata = tba_o[idx];
                default: rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/dmx_decode.sv
module dmx_decode
    import dmx_pkg::*;
#(
    parameter int NWIN = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [63:0]       base [NWIN],
    input  logic [63:0]       mask [NWIN],
    input  logic [63:0]       tba  [NWIN],
    input  logic [63:0]       ctl,
    output plan_t             plan
);

    localparam int LAST = NWIN - 1;

    logic            narrow;
    logic            in_hole;
    logic            in_pass;
    logic            in_wide;
    logic [NWIN-1:0] hit_v;

    assign narrow  = (addr[ADDR_W-1:32] == '0);
    assign in_hole = ctl[HOLE_BIT] && narrow && (addr[31:19] == 13'h0001);
    assign in_pass = ctl[PASS_BIT] && (addr[ADDR_W-1:40] == 4'h1);
    assign in_wide = addr[ADDR_W-1] && base[LAST][EN_BIT] && base[LAST][WIDE_BIT];

    for (genvar w = 0; w < NWIN; w++) begin : g_match
        logic cmp;
        assign cmp = ((addr[31:20] & ~mask[w][31:20]) == base[w][31:20]);
        if (w == LAST) begin : g_last
            assign hit_v[w] = narrow && base[w][EN_BIT] && !base[w][WIDE_BIT] && cmp;
        end else begin : g_plain
            assign hit_v[w] = narrow && base[w][EN_BIT] && cmp;
        end
    end

    always_comb begin
        logic found;
        found = 1'b0;
        plan  = '{act: ACT_MISS, sys: '0, pte: '0};
        if (narrow) begin
            if (!in_hole) begin
                for (int w = 0; w < NWIN; w++) begin
                    if (!found && hit_v[w]) begin
                        found = 1'b1;
                        if (base[w][PG_BIT]) begin
                            plan.act = ACT_FETCH;
                            plan.pte = paged_entry_addr(tba[w], mask[w], addr);
                        end else begin
                            plan.act = ACT_DIRECT;
                            plan.sys = linear_map(tba[w], mask[w], addr);
                        end
                    end
                end
            end
        end else if (in_pass) begin
            plan.act = ACT_DIRECT;
            plan.sys = addr[SYS_W-1:0];
        end else if (in_wide) begin
            plan.act = ACT_FETCH;
            plan.pte = wide_entry_addr(tba[LAST], addr);
        end
    end

endmodule

// File: rtl/dmx_walk.sv
module dmx_walk
    import dmx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [12:0]       req_off,
    input  plan_t             plan,
    output logic              req_ready,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [SYS_W-1:0]  mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [SYS_W-1:0]  rsp_addr
);

    st_e              state_q;
    logic [SYS_W-1:0] pte_q;
    logic [12:0]      off_q;

    assign req_ready     = (state_q == ST_IDLE);
    assign mem_req_valid = (state_q == ST_FETCH);
    assign mem_req_addr  = pte_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            pte_q     <= '0;
            off_q     <= '0;
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_addr  <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        case (plan.act)
                            ACT_DIRECT: begin
                                rsp_valid <= 1'b1;
                                rsp_hit   <= 1'b1;
                                rsp_addr  <= plan.sys;
                            end
                            ACT_FETCH: begin
                                pte_q   <= plan.pte;
                                off_q   <= req_off;
                                state_q <= ST_FETCH;
                            end
                            default: begin
                                rsp_valid <= 1'b1;
                                rsp_hit   <= 1'b0;
                                rsp_addr  <= '0;
                            end
                        endcase
                    end
                end
                ST_FETCH: begin
                    if (mem_req_ready) state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        rsp_valid <= 1'b1;
                        rsp_hit   <= mem_rsp_data[0];
                        rsp_addr  <= mem_rsp_data[0] ? entry_to_sys(mem_rsp_data, off_q) : '0;
                        state_q   <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pci_dma_xlat.sv
module pci_dma_xlat
    import dmx_pkg::*;
#(
    parameter int NWIN = 4,
    localparam int WIN_W = (NWIN > 1) ? $clog2(NWIN) : 1,
    localparam int SEL_W = WIN_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [63:0]       reg_wdata,
    output logic [63:0]       reg_rdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [SYS_W-1:0]  rsp_addr,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [SYS_W-1:0]  mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data
);

    logic [63:0] base_w [NWIN];
    logic [63:0] mask_w [NWIN];
    logic [63:0] tba_w  [NWIN];
    logic [63:0] ctl_q;
    plan_t       plan;

    dmx_regs #(.NWIN(NWIN), .WIN_W(WIN_W), .SEL_W(SEL_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (reg_we),
        .sel    (reg_sel),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .base_o (base_w),
        .mask_o (mask_w),
        .tba_o  (tba_w),
        .ctl_o  (ctl_q)
    );

    dmx_decode #(.NWIN(NWIN)) u_decode (
        .addr (req_addr),
        .base (base_w),
        .mask (mask_w),
        .tba  (tba_w),
        .ctl  (ctl_q),
        .plan (plan)
    );

    dmx_walk u_walk (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_off       (req_addr[12:0]),
        .plan          (plan),
        .req_ready     (req_ready),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .rsp_valid     (rsp_valid),
        .rsp_hit       (rsp_hit),
        .rsp_addr      (rsp_addr)
    );

endmodule

// File: rtl/dmx_checker.sv
module dmx_checker
    import dmx_pkg::*;
#(
    parameter int SEL_W = 4,
    parameter int LAST  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [SEL_W-1:0]  reg_sel,
    input logic [63:0]       reg_rdata,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [SYS_W-1:0]  rsp_addr,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [SYS_W-1:0]  mem_req_addr,
    input logic [63:0]       ctl
);

    p_last_paged_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_sel == SEL_W'(LAST)) |-> reg_rdata[PG_BIT]);

    p_ctl_keep_r3: assert property (@(posedge clk) disable iff (rst)
        (reg_sel[SEL_W-1 -: 2] == 2'd3) |-> ((reg_rdata & ~CTL_KEEP) == 64'h0));

    p_read_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    p_hole_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && ctl[HOLE_BIT] && req_addr[ADDR_W-1:19] == 25'h1)
        |=> (rsp_valid && !rsp_hit));

    p_pass_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && ctl[PASS_BIT] && req_addr[ADDR_W-1:40] == 4'h1)
        |=> (rsp_valid && rsp_hit && rsp_addr == $past(req_addr[SYS_W-1:0])));

    p_single_flight_r10: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !req_ready);

    p_miss_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_addr == '0));

    p_rsp_idle_r10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> req_ready);

endmodule

bind pci_dma_xlat dmx_checker #(.SEL_W(SEL_W), .LAST(NWIN - 1)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .reg_sel       (reg_sel),
    .reg_rdata     (reg_rdata),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_addr      (req_addr),
    .rsp_valid     (rsp_valid),
    .rsp_hit       (rsp_hit),
    .rsp_addr      (rsp_addr),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .ctl           (ctl_q)
);

// File: tb/pci_dma_xlat_test.sv
`timescale 1ns/1ps
module pci_dma_xlat_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_sel = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [43:0] req_addr = '0;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [34:0] rsp_addr;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [34:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;

    always #2 clk = ~clk;

    pci_dma_xlat uut (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_addr(rsp_addr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    int n_chk = 0;
    int n_err = 0;
    int n_mem = 0;
    int mem_lat = 0;
    int mem_stall = 0;
    bit expecting = 1'b0;
    bit done = 1'b0;
    logic [63:0] exp_pte = '0;

    logic [63:0] m_base [4];
    logic [63:0] m_mask [4];
    logic [63:0] m_tba  [4];
    logic [63:0] m_ctl;
    logic [63:0] pte_mem [logic [63:0]];

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    function automatic logic [63:0] mem_rd(input logic [63:0] a);
        if (pte_mem.exists(a)) return pte_mem[a];
        return 64'h0;
    endfunction

    // Behavioural model of the translation rules
    function automatic void ref_xlate(input logic [63:0] a, output int kind,
                                      output logic [63:0] sys, output logic [63:0] pte);
        logic [63:0] ext;
        kind = 0; sys = 0; pte = 0;
        if (a < 64'h1_0000_0000) begin
            if (m_ctl[5] && a >= 64'h8_0000 && a <= 64'hF_FFFF) return;
            for (int w = 0; w < 4; w++) begin
                if (w == 3 && m_base[3][39]) continue;
                if (!m_base[w][0]) continue;
                ext = m_mask[w] | 64'hF_FFFF;
                if ((a & ~ext) != (m_base[w] & 64'hFFF0_0000)) continue;
                if (m_base[w][1]) begin
                    kind = 2;
                    pte = (m_tba[w] & ~(m_mask[w] >> 10)) | ((a & (m_mask[w] | 64'hF_E000)) >> 10);
                end else begin
                    kind = 1;
                    sys = (m_tba[w] & ~ext) | (a & ext);
                end
                return;
            end
        end else begin
            if (m_ctl[6] && a >= (64'h1 << 40) && a < (64'h1 << 41)) begin
                kind = 1;
                sys = a & 64'h7_FFFF_FFFF;
            end else if (a >= (64'h1 << 43) && a < (64'h1 << 44) && m_base[3][0] && m_base[3][39]) begin
                kind = 2;
                pte = (m_tba[3] & 64'h7_FFC0_0000) | ((a & 64'hFFFF_E000) >> 10);
            end
        end
    endfunction

    task automatic wr(input int kind, input int win, input logic [63:0] val);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = {2'(kind), 2'(win)}; reg_wdata = val;
        @(negedge clk);
        reg_we = 1'b0;
        case (kind)
            0: m_base[win] = (win == 3) ? ((val & 64'h80_FFF0_0001) | 64'h2) : (val & 64'hFFF0_0003);
            1: m_mask[win] = val & 64'hFFF0_0000;
            2: m_tba[win]  = val & 64'h7_FFFF_FC00;
            default: m_ctl = val & 64'h1C_FF0F_C7FF;
        endcase
    endtask

    task automatic rd_chk(input int kind, input int win, input string rq);
        logic [63:0] e;
        @(negedge clk);
        reg_sel = {2'(kind), 2'(win)};
        #1;
        case (kind)
            0: e = m_base[win];
            1: e = m_mask[win];
            2: e = m_tba[win];
            default: e = m_ctl;
        endcase
        chk(reg_rdata === e, rq, $sformatf("readback kind %0d win %0d", kind, win), reg_rdata, e);
    endtask

    task automatic xlate(input logic [63:0] a, input string rq);
        int kind;
        logic [63:0] sys, pte, d, esys;
        int mem0;
        bit got;
        ref_xlate(a, kind, sys, pte);
        @(negedge clk);
        chk(req_ready === 1'b1, "R10", "idle before request", 64'(req_ready), 64'h1);
        req_valid = 1'b1; req_addr = a[43:0]; exp_pte = pte; expecting = 1'b1;
        mem0 = n_mem;
        @(negedge clk);
        req_valid = 1'b0;
        if (kind != 2) begin
            chk(rsp_valid === 1'b1, "R10", "response one cycle after accept", 64'(rsp_valid), 64'h1);
            chk(rsp_hit === (kind == 1), rq, $sformatf("hit for %h", a), 64'(rsp_hit), 64'(kind == 1));
            chk(64'(rsp_addr) === sys, rq, $sformatf("address for %h", a), 64'(rsp_addr), sys);
        end else begin
            chk(rsp_valid === 1'b0 && req_ready === 1'b0, "R10", "busy during fetch",
                64'({rsp_valid, req_ready}), 64'h0);
            got = 1'b0;
            for (int i = 0; i < 40 && !got; i++) begin
                if (rsp_valid === 1'b1) got = 1'b1;
                else @(negedge clk);
            end
            d = mem_rd(pte);
            esys = d[0] ? (((d & 64'h3F_FFFE) << 12) | (a & 64'h1FFF)) : 64'h0;
            chk(got, rq, $sformatf("paged response for %h", a), 64'(got), 64'h1);
            chk(rsp_hit === d[0], rq, $sformatf("paged hit for %h", a), 64'(rsp_hit), 64'(d[0]));
            chk(64'(rsp_addr) === esys, rq, $sformatf("paged address for %h", a), 64'(rsp_addr), esys);
            chk(n_mem == mem0 + 1, rq, "single entry read", 64'(n_mem - mem0), 64'h1);
        end
        @(negedge clk);
        expecting = 1'b0;
    endtask

    // Memory responder
    initial begin
        logic [63:0] a;
        forever begin
            @(negedge clk);
            if (mem_req_valid === 1'b1) begin
                a = 64'(mem_req_addr);
                n_mem++;
                chk(a === exp_pte, "R6", "entry read address", a, exp_pte);
                repeat (mem_stall) @(negedge clk);
                mem_req_ready = 1'b1;
                @(negedge clk);
                mem_req_ready = 1'b0;
                repeat (mem_lat) @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data = mem_rd(a);
                @(negedge clk);
                mem_rsp_valid = 1'b0;
            end
        end
    end

    // Spurious response monitor, every cycle
    always @(negedge clk) begin
        if (!rst && rsp_valid === 1'b1 && !expecting)
            chk(1'b0, "R10", "unexpected response", 64'h1, 64'h0);
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        for (int w = 0; w < 4; w++) begin
            m_base[w] = '0; m_mask[w] = '0; m_tba[w] = '0;
        end
        m_base[3] = 64'h2;
        m_ctl = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(req_ready === 1'b1, "R10", "reset ready", 64'(req_ready), 64'h1);
        chk(rsp_valid === 1'b0, "R10", "reset response", 64'(rsp_valid), 64'h0);
        chk(mem_req_valid === 1'b0, "R10", "reset mem request", 64'(mem_req_valid), 64'h0);
        for (int w = 0; w < 4; w++) begin
            rd_chk(0, w, (w == 3) ? "R2" : "R1");
            rd_chk(1, w, "R1");
            rd_chk(2, w, "R1");
        end
        rd_chk(3, 0, "R3");

        // all-ones masking
        for (int w = 0; w < 4; w++) begin
            wr(0, w, '1); wr(1, w, '1); wr(2, w, '1);
        end
        wr(3, 0, '1);
        for (int w = 0; w < 4; w++) begin
            rd_chk(0, w, (w == 3) ? "R2" : "R1");
            rd_chk(1, w, "R1");
            rd_chk(2, w, "R1");
        end
        rd_chk(3, 2, "R3");
        wr(0, 3, 64'h0);
        rd_chk(0, 3, "R2");

        // programming
        wr(3, 0, 64'h0);
        wr(0, 0, 64'h4000_0001); wr(1, 0, 64'h0FF0_0000); wr(2, 0, 64'h1_2000_0000);
        wr(0, 1, 64'h8000_0003); wr(1, 1, 64'h0);         wr(2, 1, 64'h10_0000);
        wr(0, 2, 64'h4000_0001); wr(1, 2, 64'h0);         wr(2, 2, 64'h3_0000_0000);
        wr(0, 3, 64'hC000_0001); wr(1, 3, 64'h0);         wr(2, 3, 64'h2000_0000);
        pte_mem[64'h10_00D0]   = 64'hDEAD_0000_0012_3401;
        pte_mem[64'h10_0008]   = 64'h0000_0000_003F_FFFE;
        pte_mem[64'h2000_0018] = 64'h0000_0000_0003_FFFF;
        pte_mem[64'h2004_8D18] = 64'h0000_0000_0001_5555;

        xlate(64'h4123_4567, "R5");
        xlate(64'h4000_0ABC, "R4");
        xlate(64'h5000_0000, "R4");
        xlate(64'h8003_5A5A, "R6");
        mem_lat = 3; mem_stall = 2;
        xlate(64'h8003_4010, "R6");
        mem_lat = 1; mem_stall = 0;
        xlate(64'h8000_2000, "R6");
        xlate(64'hC000_6123, "R4");
        wr(0, 0, 64'h0);
        xlate(64'h4000_0ABC, "R4");

        wr(0, 3, 64'h80_C000_0001);
        rd_chk(0, 3, "R2");
        xlate(64'hC000_6123, "R4");
        xlate(64'h800_1234_6000, "R9");
        wr(0, 3, 64'hC000_0001);
        xlate(64'h800_1234_6000, "R9");

        wr(0, 2, 64'h0000_0001); wr(1, 2, 64'h0);
        wr(3, 0, 64'h20);
        xlate(64'h9_0000, "R7");
        xlate(64'h7_FFFF, "R7");
        xlate(64'hF_FFFF, "R7");
        wr(3, 0, 64'h0);
        xlate(64'h9_0000, "R7");

        wr(3, 0, 64'h40);
        xlate(64'h155_5555_5555, "R8");
        xlate(64'h200_0000_0000, "R8");
        wr(3, 0, 64'h0);
        xlate(64'h155_5555_5555, "R11");
        xlate(64'h1_0000_0000, "R11");

        done = 1'b1;
        report();
        $finish;
    end

endmodule